// File: doc/BRIEF.md
# RAM Data and Address Parity Wrapper

A synchronous single-port RAM that keeps two check bits beside every 32-bit word. The data check bit is even parity over the word written. The address check bit is even parity over the access address. Only the offset bits that select a word inside the block count towards it. The base bits above the block are ignored, and so is the lowest address bit, because each 32-bit access spans two 16-bit addressable units. On every read both bits are recomputed, from the returned data and from the read address, and compared with the stored ones. A mismatch raises a one-cycle error pulse that is aligned with the read data.

A 2-bit test-mode input lets software plant a wrong address check bit. When it is `2'b10`, the stored address bit is taken from write-data bit 16 and not computed. A later read of that word then shows whether the checker catches the fault. The offset width, and with it the address mask, follows from the block-size parameter. The default is a 4 KB block with 16-bit addressable units, which gives the mask 0x7FE. An 8 KB block gives 0xFFE.

Top module: `parity_ram`

## Requirements
- R1: A read request (`re_i` high, `we_i` low) returns the word last written to that location on `rdata_o` one clock later, with `rvalid_o` high for exactly that cycle. `rvalid_o` is low in every other cycle.
- R2: The data check bit stored on a write makes the count of ones across the 32 data bits and that bit even. A read of a word written in any mode never raises `data_err_o`.
- R3: The word index and the address check bit use only the address bits under the offset mask. With default parameters this is bits 10..1 (mask 0x7FE), so two addresses that differ only in bits 15..11 reach the same word, and a read through either raises no error.
- R4: Address bit 0 takes no part in word selection or address parity. Reading the odd address of a pair returns the word written through the even one, with no error.
- R5: When `test_mode_i` is `2'b10` during a write, the stored address check bit equals `wdata_i[16]`. A later read raises `addr_err_o` exactly when that bit differs from the even parity of the masked read address. Example: 0x877E and 0x8F8E both have parity 1, so injecting 1 at either gives no error, and injecting 0 at 0x877E gives an error.
- R6: For `test_mode_i` values 2'b00, 2'b01 and 2'b11, both check bits are computed. A later read raises no error.
- R7: `data_err_o` and `addr_err_o` are single-cycle pulses that are only high in a cycle where `rvalid_o` is high.
- R8: When `we_i` and `re_i` are high in the same cycle, only the write is performed. No read response follows (`rvalid_o` low next cycle), and a later read returns the new data.
- R9: While `rst_ni` is low, `rvalid_o`, `data_err_o` and `addr_err_o` are low. Memory contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Access address in 16-bit units (base bits ignored) |
| we_i | input | 1 | Write request |
| re_i | input | 1 | Read request |
| wdata_i | input | 32 | Write data; bit 16 is the injected address check bit in test mode 2'b10 |
| test_mode_i | input | 2 | 2'b10 injects the address check bit; other values compute it |
| rdata_o | output | 32 | Read data, valid one cycle after the request |
| rvalid_o | output | 1 | Read data valid |
| data_err_o | output | 1 | Data parity mismatch on this read |
| addr_err_o | output | 1 | Address parity mismatch on this read |

## Verification
A wrong stored address check bit, or a mask that covers a base bit or bit 0, shows up as an `addr_err_o` pulse on the first read of the affected word. That read is one cycle after the request, or the pulse is missing where an injected fault should fire. A stuck or mistimed read stage shows up as wrong data, or as `rvalid_o` in the wrong cycle, on the very next clock. Base aliasing and odd-address reads prove that the index and the parity use the same masked bits. The two published example addresses pin the parity polarity.

// File: rtl/parity_ram_pkg.sv
package parity_ram_pkg;
  typedef enum logic [1:0] {
    TM_NORM  = 2'b00,
    TM_RSV1  = 2'b01,
    TM_INJ_A = 2'b10,
    TM_RSV3  = 2'b11
  } test_mode_e;

  localparam int unsigned AP_INJ_BIT = 16;
endpackage

// File: rtl/parity_gen.sv
module parity_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned LOW_W  = 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              data_par_o,
  output logic              addr_par_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << LOW_W) - 64'd1);
  localparam logic [ADDR_W-1:0] AP_MASK  = OFF_MASK & ~LOW_MASK;

  assign data_par_o = ^data_i;
  assign addr_par_o = ^(addr_i & AP_MASK);
endmodule

// File: rtl/parity_ram_array.sv
module parity_ram_array #(
  parameter int unsigned WORD_W = 34,
  parameter int unsigned IDX_W  = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wword_i,
  output logic [WORD_W-1:0] rword_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wword_i;
  end

  // read port only fires when no write is pending (write wins)
  always_ff @(posedge clk_i) begin
    if (re_i && !we_i) rword_o <= mem_q[idx_i];
  end
endmodule

// File: rtl/parity_check.sv
module parity_check (
  input  logic valid_i,
  input  logic stored_dp_i,
  input  logic stored_ap_i,
  input  logic calc_dp_i,
  input  logic calc_ap_i,
  output logic data_err_o,
  output logic addr_err_o
);
  assign data_err_o = valid_i & (stored_dp_i ^ calc_dp_i);
  assign addr_err_o = valid_i & (stored_ap_i ^ calc_ap_i);
endmodule

// File: rtl/parity_ram.sv
module parity_ram
  import parity_ram_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BLOCK_BYTES = 4096,
  parameter int unsigned UNIT_BYTES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        test_mode_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              data_err_o,
  output logic              addr_err_o
);
  localparam int unsigned OFF_W  = $clog2(BLOCK_BYTES / UNIT_BYTES);
  localparam int unsigned LOW_W  = $clog2(DATA_W / (8 * UNIT_BYTES));
  localparam int unsigned IDX_W  = OFF_W - LOW_W;
  localparam int unsigned WORD_W = DATA_W + 2;

  logic              wr_dp, wr_ap_calc, wr_ap;
  logic              rd_dp, rd_ap;
  logic [WORD_W-1:0] wword, rword;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rvalid_q;
  logic              rd_go;

  assign rd_go = re_i & ~we_i;

  parity_gen #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LOW_W(LOW_W)
  ) i_gen_wr (
    .data_i    (wdata_i),
    .addr_i    (addr_i),
    .data_par_o(wr_dp),
    .addr_par_o(wr_ap_calc)
  );

  assign wr_ap = (test_mode_e'(test_mode_i) == TM_INJ_A) ? wdata_i[AP_INJ_BIT] : wr_ap_calc;
  assign wword = {wr_ap, wr_dp, wdata_i};

  parity_ram_array #(
    .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) i_array (
    .clk_i  (clk_i),
    .we_i   (we_i),
    .re_i   (re_i),
    .idx_i  (addr_i[OFF_W-1:LOW_W]),
    .wword_i(wword),
    .rword_o(rword)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rvalid_q <= rd_go;
      if (rd_go) rd_addr_q <= addr_i;
    end
  end

  parity_gen #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LOW_W(LOW_W)
  ) i_gen_rd (
    .data_i    (rword[DATA_W-1:0]),
    .addr_i    (rd_addr_q),
    .data_par_o(rd_dp),
    .addr_par_o(rd_ap)
  );

  parity_check i_check (
    .valid_i    (rvalid_q),
    .stored_dp_i(rword[DATA_W]),
    .stored_ap_i(rword[DATA_W+1]),
    .calc_dp_i  (rd_dp),
    .calc_ap_i  (rd_ap),
    .data_err_o (data_err_o),
    .addr_err_o (addr_err_o)
  );

  assign rdata_o  = rword[DATA_W-1:0];
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/parity_ram_chk.sv
module parity_ram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic we_i,
  input logic re_i,
  input logic rvalid_o,
  input logic data_err_o,
  input logic addr_err_o
);
  assert_read_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i) |=> rvalid_o);

  assert_no_spurious_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !rvalid_o);

  assert_data_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !data_err_o);

  assert_err_with_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_err_o || addr_err_o) |-> rvalid_o);

  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !rvalid_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R9: assert (!rvalid_o && !data_err_o && !addr_err_o);
    end
  end
endmodule

bind parity_ram parity_ram_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .re_i      (re_i),
  .rvalid_o  (rvalid_o),
  .data_err_o(data_err_o),
  .addr_err_o(addr_err_o)
);

// File: tb/test_parity_ram.sv
`timescale 1ns/1ps
module test_parity_ram;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [15:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  test_mode_i = 2'b00;
  logic [31:0] rdata_o;
  logic        rvalid_o, data_err_o, addr_err_o;

  int total = 0;
  int bad = 0;

  logic [31:0] ref_d  [1024];
  logic        ref_ap [1024];
  logic        ref_ok [1024];

  always #10 clk_i = ~clk_i;

  parity_ram i_parity_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
    .wdata_i(wdata_i), .test_mode_i(test_mode_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .data_err_o(data_err_o), .addr_err_o(addr_err_o)
  );

  function automatic logic exp_ap(input logic [15:0] a);
    return ^(a & 16'h07FE);
  endfunction

  function automatic int idx_of(input logic [15:0] a);
    return int'(a[10:1]);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] tm);
    addr_i = a; wdata_i = d; test_mode_i = tm; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    ref_d[idx_of(a)]  = d;
    ref_ap[idx_of(a)] = (tm == 2'b10) ? d[16] : exp_ap(a);
    ref_ok[idx_of(a)] = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    logic eae;
    eae = ref_ap[idx_of(a)] ^ exp_ap(a);
    addr_i = a; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    check({tag, " R1 valid"}, 64'(rvalid_o), 64'd1);
    check({tag, " R1 data"}, 64'(rdata_o), 64'(ref_d[idx_of(a)]));
    check({tag, " R2 derr"}, 64'(data_err_o), 64'd0);
    check({tag, " aerr"}, 64'(addr_err_o), 64'(eae));
    @(negedge clk_i);
    check({tag, " R7 pulse"}, 64'({rvalid_o, data_err_o, addr_err_o}), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 1024; i++) ref_ok[i] = 1'b0;
    #5 rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check("R9 reset outputs", 64'({rvalid_o, data_err_o, addr_err_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 / example addresses: both masked parities equal 1
    wr(16'h877E, 32'h0001_0000, 2'b10);
    rd(16'h877E, "R5 inj 1 at 877E");
    wr(16'h8F8E, 32'hA5A5_5A5A | 32'h0001_0000, 2'b10);
    rd(16'h8F8E, "R5 inj 1 at 8F8E");
    wr(16'h877E, 32'h1234_5678 & ~32'h0001_0000, 2'b10);
    check("R5 expect error", 64'(ref_ap[idx_of(16'h877E)] ^ exp_ap(16'h877E)), 64'd1);
    rd(16'h877E, "R5 inj 0 at 877E");

    // R3 base ignored, R4 bit 0 ignored
    wr(16'h877E, 32'hDEAD_BEEF, 2'b00);
    rd(16'h077E, "R3 base 0");
    rd(16'hF77E, "R3 base F");
    rd(16'h877F, "R4 odd addr");

    // R6 other modes compute
    wr(16'h0010, 32'h0001_0001, 2'b01);
    rd(16'h0010, "R6 mode 01");
    wr(16'h0012, 32'hFFFF_0000, 2'b11);
    rd(16'h0012, "R6 mode 11");

    // R8 write wins
    addr_i = 16'h0020; wdata_i = 32'hCAFE_F00D; test_mode_i = 2'b00;
    we_i = 1'b1; re_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
    ref_d[idx_of(16'h0020)] = 32'hCAFE_F00D;
    ref_ap[idx_of(16'h0020)] = exp_ap(16'h0020);
    ref_ok[idx_of(16'h0020)] = 1'b1;
    check("R8 no read response", 64'(rvalid_o), 64'd0);
    rd(16'h0020, "R8 new data");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [1:0]  tm;
      a  = 16'($urandom);
      tm = 2'($urandom);
      if (($urandom % 2) == 0) wr(a, $urandom, tm);
      if (ref_ok[idx_of(a)]) rd(a ^ 16'($urandom & 32'hF801), "R5 R6 random");
      else @(negedge clk_i);
    end

    // R9 reset mid-run
    addr_i = 16'h877E; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R9 reset clears", 64'({rvalid_o, data_err_o, addr_err_o}), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule